// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating state of a DRAM protocol controller and moves it only along a fixed set of paths. Software writes a 3-bit state command. It reads back a status word that holds the current state and, during low power, the cause of the low-power entry. The stable states are memory-init, configuration, access and low power. Every move between them passes through a request state that software can see. A request state lasts a programmable number of cycles and may also wait for a handshake input. Two stub inputs stand in for the DRAM power-up event and the DLL-lock event.

Low power can be entered in two ways: by a software sleep command, or by an automatic idle request from the controller. A hardware-caused low-power period belongs to hardware. A software wake command cannot end it; it ends when the automatic request drops. Configuration cannot be reached from low power. The block must first return to access.

Top module: `dram_opstate_ctrl`

## Requirements
- R1: After reset the status reads state 0 (memory-init) with trigger field 0.
- R2: The command codes are INIT=0, CFG=1, GO=2, SLEEP=3, WAKEUP=4. Status bits [2:0] hold the state: memory-init=0, config=1, config-request=2, access=3, access-request=4, low-power=5, entry-request=6, exit-request=7. Bit 3 reads 0. Bits [6:4] hold the trigger: 0 none, 1 hardware, 2 software.
- R3: CFG in memory-init moves to config-request. That state ends in config only once the request length has elapsed and pwr_up_done is high.
- R4: CFG in access moves to config-request, then to config after the request length, whatever pwr_up_done is.
- R5: GO in config moves to access-request, then to access after the request length.
- R6: SLEEP in access moves to entry-request, then to low power after the request length. The trigger reads 2 from entry-request until access is reached again, and it reads 0 in every state outside the low-power group.
- R7: WAKEUP in low power with a software trigger moves to exit-request. That state ends in access, with the trigger cleared, once the request length has elapsed and dll_lock is high.
- R8: No command leads from low power to config or config-request. CFG and GO in low power leave the status unchanged.
- R9: A command not listed for the current state is ignored and the status does not change. This covers every command during a request state, INIT in any state, and the codes 5 to 7.
- R10: The request length is taken from req_len when the command is accepted. It counts the cycles the request state is visible when no handshake holds it. A req_len of 0 selects the default of 4 cycles.
- R11: In access with no accepted command, a high auto_lp_req starts an entry with trigger 1. In low power with trigger 1, WAKEUP is ignored while auto_lp_req is high, and a low auto_lp_req starts the exit request. In low power with trigger 2, auto_lp_req has no effect.
- R12: In access, a legal software command takes priority over auto_lp_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | State command code |
| req_len | input | LEN_W | Request-state length in cycles, 0 selects the default |
| auto_lp_req | input | 1 | Controller idle request for low power |
| pwr_up_done | input | 1 | DRAM power-up complete (stub) |
| dll_lock | input | 1 | PHY DLL locked (stub) |
| status_o | output | 7 | {trigger[2:0], 0, state[2:0]} |

## Verification
On every cycle, the checker confirms the path rules. Config is entered only from config-request, low power exits only through exit-request, and the access request finishes only in access. It also confirms that a request state holds while its timer runs or while its power-up or lock handshake is missing. It further checks that the trigger is non-zero exactly in the low-power group and that a hardware low-power period holds while auto_lp_req is high. Some behaviour can only be shown by the bench scenarios: the exact length of each request state for default and programmed values, the priority of a software sleep over the automatic request, and the rejection of illegal codes in stable states.

// File: rtl/dos_pkg.sv
package dos_pkg;

  typedef enum logic [2:0] {
    ST_INIT_MEM    = 3'd0,
    ST_CONFIG      = 3'd1,
    ST_CONFIG_REQ  = 3'd2,
    ST_ACCESS      = 3'd3,
    ST_ACCESS_REQ  = 3'd4,
    ST_LOW_POWER   = 3'd5,
    ST_LP_ENTER    = 3'd6,
    ST_LP_EXIT     = 3'd7
  } op_state_e;

  localparam logic [2:0] CMD_INIT  = 3'd0;
  localparam logic [2:0] CMD_CFG   = 3'd1;
  localparam logic [2:0] CMD_GO    = 3'd2;
  localparam logic [2:0] CMD_SLEEP = 3'd3;
  localparam logic [2:0] CMD_WAKE  = 3'd4;

  localparam logic [2:0] TRIG_NONE = 3'd0;
  localparam logic [2:0] TRIG_HW   = 3'd1;
  localparam logic [2:0] TRIG_SW   = 3'd2;

  function automatic logic is_request(input op_state_e s);
    return (s == ST_CONFIG_REQ) || (s == ST_ACCESS_REQ) ||
           (s == ST_LP_ENTER)   || (s == ST_LP_EXIT);
  endfunction

  function automatic logic in_lp_group(input op_state_e s);
    return (s == ST_LOW_POWER) || (s == ST_LP_ENTER) || (s == ST_LP_EXIT);
  endfunction

  function automatic op_state_e request_target(input op_state_e s);
    case (s)
      ST_CONFIG_REQ: return ST_CONFIG;
      ST_ACCESS_REQ: return ST_ACCESS;
      ST_LP_ENTER:   return ST_LOW_POWER;
      ST_LP_EXIT:    return ST_ACCESS;
      default:       return s;
    endcase
  endfunction

endpackage

// File: rtl/dos_cmd_filter.sv
module dos_cmd_filter
  import dos_pkg::*;
(
  input  op_state_e   state,
  input  logic [2:0]  trig,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_code,
  input  logic        auto_lp_req,
  output logic        start,
  output op_state_e   start_state,
  output logic [2:0]  start_trig
);

  logic is_cfg, is_go, is_sleep, is_wake;

  always_comb begin
    is_cfg   = cmd_valid && (cmd_code == CMD_CFG);
    is_go    = cmd_valid && (cmd_code == CMD_GO);
    is_sleep = cmd_valid && (cmd_code == CMD_SLEEP);
    is_wake  = cmd_valid && (cmd_code == CMD_WAKE);
  end

  always_comb begin
    start       = 1'b0;
    start_state = state;
    start_trig  = TRIG_NONE;
    case (state)
      ST_INIT_MEM: begin
        if (is_cfg) begin
          start       = 1'b1;
          start_state = ST_CONFIG_REQ;
        end
      end
      ST_CONFIG: begin
        if (is_go) begin
          start       = 1'b1;
          start_state = ST_ACCESS_REQ;
        end
      end
      ST_ACCESS: begin
        if (is_cfg) begin
          start       = 1'b1;
          start_state = ST_CONFIG_REQ;
        end else if (is_sleep) begin
          start       = 1'b1;
          start_state = ST_LP_ENTER;
          start_trig  = TRIG_SW;
        end else if (auto_lp_req) begin
          start       = 1'b1;
          start_state = ST_LP_ENTER;
          start_trig  = TRIG_HW;
        end
      end
      ST_LOW_POWER: begin
        if (trig == TRIG_HW) begin
          if (!auto_lp_req) begin
            start       = 1'b1;
            start_state = ST_LP_EXIT;
          end
        end else if (is_wake) begin
          start       = 1'b1;
          start_state = ST_LP_EXIT;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dos_req_timer.sv
module dos_req_timer #(
  parameter int LEN_W   = 8,
  parameter int DEF_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             run,
  output logic             zero
);

  localparam logic [LEN_W-1:0] DEF_FIRST = LEN_W'(DEF_LEN - 1);

  function automatic logic [LEN_W-1:0] first_count(input logic [LEN_W-1:0] l);
    return (l == '0) ? DEF_FIRST : l - 1'b1;
  endfunction

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= first_count(len);
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dos_lp_trigger.sv
module dos_lp_trigger (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic [2:0] set_val,
  input  logic       clear,
  output logic [2:0] trig
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      trig <= 3'd0;
    else if (set)
      trig <= set_val;
    else if (clear)
      trig <= 3'd0;
  end

endmodule

// File: rtl/dram_opstate_ctrl.sv
module dram_opstate_ctrl
  import dos_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int DEF_REQ_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [LEN_W-1:0] req_len,
  input  logic             auto_lp_req,
  input  logic             pwr_up_done,
  input  logic             dll_lock,
  output logic [6:0]       status_o
);

  op_state_e  state_q;
  logic       cfg_from_init;
  logic       start;
  op_state_e  start_state;
  logic [2:0] start_trig;
  logic [2:0] trig;
  logic       timer_zero;
  logic       in_req;
  logic       gate_ok;
  logic       req_done;
  logic       lp_set;
  logic       lp_clear;

  dos_cmd_filter u_filter (
    .state       (state_q),
    .trig        (trig),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .auto_lp_req (auto_lp_req),
    .start       (start),
    .start_state (start_state),
    .start_trig  (start_trig)
  );

  assign in_req = is_request(state_q);

  dos_req_timer #(
    .LEN_W   (LEN_W),
    .DEF_LEN (DEF_REQ_LEN)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .len   (req_len),
    .run   (in_req),
    .zero  (timer_zero)
  );

  always_comb begin
    case (state_q)
      ST_CONFIG_REQ: gate_ok = !cfg_from_init || pwr_up_done;
      ST_LP_EXIT:    gate_ok = dll_lock;
      default:       gate_ok = 1'b1;
    endcase
  end

  assign req_done = in_req && timer_zero && gate_ok;
  assign lp_set   = start && (start_state == ST_LP_ENTER);
  assign lp_clear = req_done && (state_q == ST_LP_EXIT);

  dos_lp_trigger u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (lp_set),
    .set_val (start_trig),
    .clear   (lp_clear),
    .trig    (trig)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_INIT_MEM;
      cfg_from_init <= 1'b0;
    end else if (start) begin
      state_q       <= start_state;
      cfg_from_init <= (state_q == ST_INIT_MEM);
    end else if (req_done) begin
      state_q       <= request_target(state_q);
    end
  end

  assign status_o = {trig, 1'b0, state_q};

endmodule

// File: rtl/dos_checker.sv
module dos_checker
  import dos_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input op_state_e  state,
  input logic [2:0] trig,
  input logic       from_init,
  input logic       timer_zero,
  input logic       pwr_up_done,
  input logic       dll_lock,
  input logic       auto_lp_req
);

  // R3 R4
  cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CONFIG && state != ST_CONFIG_REQ) |=> state != ST_CONFIG);

  // R3
  pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONFIG_REQ && from_init && !pwr_up_done) |=> state == ST_CONFIG_REQ);

  // R7
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LP_EXIT && !dll_lock) |=> state == ST_LP_EXIT);

  // R8
  lp_no_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LOW_POWER |=> (state == ST_LOW_POWER || state == ST_LP_EXIT));

  // R6
  trig_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != 3'd0) == in_lp_group(state));

  // R11
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW_POWER && trig == TRIG_HW && auto_lp_req) |=> state == ST_LOW_POWER);

  // R5
  go_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ACCESS_REQ |=> (state == ST_ACCESS_REQ || state == ST_ACCESS));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_request(state) && !timer_zero) |=> state == $past(state));

endmodule

bind dram_opstate_ctrl dos_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (state_q),
  .trig        (trig),
  .from_init   (cfg_from_init),
  .timer_zero  (timer_zero),
  .pwr_up_done (pwr_up_done),
  .dll_lock    (dll_lock),
  .auto_lp_req (auto_lp_req)
);

// File: tb/dram_opstate_ctrl_tb_top.sv
module dram_opstate_ctrl_tb_top;

  localparam int LW = 8;
  localparam logic [2:0] C_INIT = 3'd0, C_CFG = 3'd1, C_GO = 3'd2,
                         C_SLEEP = 3'd3, C_WAKE = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_code;
  logic [LW-1:0] req_len;
  logic          auto_lp_req;
  logic          pwr_up_done;
  logic          dll_lock;
  logic [6:0]    status_o;

  always #5 clk = ~clk;

  dram_opstate_ctrl #(.LEN_W(LW), .DEF_REQ_LEN(4)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .req_len     (req_len),
    .auto_lp_req (auto_lp_req),
    .pwr_up_done (pwr_up_done),
    .dll_lock    (dll_lock),
    .status_o    (status_o)
  );

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   reported = 0;

  function automatic logic [6:0] stat(input int s, input int t);
    return {t[2:0], 1'b0, s[2:0]};
  endfunction

  task automatic compare(input logic [6:0] exp, input string tag);
    n_checks++;
    if (status_o !== exp) begin
      n_fails++;
      $display("FAIL %s: status got %h expected %h", tag, status_o, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Driver: drive this cycle's inputs, queue the status expected after the next edge.
  task automatic cyc(input bit v, input logic [2:0] c, input int s, input int t,
                     input string tag);
    cmd_valid = v;
    cmd_code  = c;
    q.push_back('{stat(s, t), tag});
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int s, input int t, input string tag);
    for (int i = 0; i < n; i++) cyc(0, C_INIT, s, t, tag);
  endtask

  // Monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        compare(e.exp, e.tag);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_code = 0; req_len = 0;
    auto_lp_req = 0; pwr_up_done = 0; dll_lock = 0;
    repeat (3) @(negedge clk);
    compare(stat(0, 0), "R1 R2 reset state");
    rst_n = 1;

    // R3 R10: default length, then held for power-up
    cyc(1, C_CFG, 2, 0, "R3 cfg request");
    idle(3, 2, 0, "R10 default length");
    idle(2, 2, 0, "R3 waits power-up");
    pwr_up_done = 1;
    cyc(0, C_INIT, 1, 0, "R3 config reached");

    // R9 illegal in config
    cyc(1, C_SLEEP, 1, 0, "R9 sleep in config");
    cyc(1, C_WAKE, 1, 0, "R9 wake in config");
    cyc(1, 3'd6, 1, 0, "R9 code 6");

    // R5 R10 R9: length 2, command during request ignored
    req_len = 2;
    cyc(1, C_GO, 4, 0, "R5 access request");
    cyc(1, C_CFG, 4, 0, "R9 cmd in request");
    cyc(0, C_INIT, 3, 0, "R5 R10 access after 2");

    // R6 R10: default length sleep
    req_len = 0;
    cyc(1, C_SLEEP, 6, 2, "R6 entry request");
    idle(3, 6, 2, "R10 default entry");
    cyc(0, C_INIT, 5, 2, "R6 low power");

    // R8
    cyc(1, C_CFG, 5, 2, "R8 cfg in low power");
    cyc(1, C_GO, 5, 2, "R8 go in low power");

    // R7: length 1, waits for lock
    req_len = 1;
    cyc(1, C_WAKE, 7, 2, "R7 exit request");
    cyc(0, C_INIT, 7, 2, "R7 waits lock");
    dll_lock = 1;
    cyc(0, C_INIT, 3, 0, "R7 access, trigger cleared");

    // R4: length 3, no power-up gate from access
    pwr_up_done = 0;
    req_len = 3;
    cyc(1, C_CFG, 2, 0, "R4 cfg request");
    idle(2, 2, 0, "R4 request held");
    cyc(0, C_INIT, 1, 0, "R4 config");
    cyc(1, C_GO, 4, 0, "R5 access request");
    idle(2, 4, 0, "R5 request held");
    cyc(0, C_INIT, 3, 0, "R5 access");

    // R12: sleep beats auto request
    req_len = 2;
    auto_lp_req = 1;
    cyc(1, C_SLEEP, 6, 2, "R12 software trigger");
    cyc(0, C_INIT, 6, 2, "R12 entry held");
    cyc(0, C_INIT, 5, 2, "R6 low power");
    auto_lp_req = 0;
    cyc(0, C_INIT, 5, 2, "R11 auto drop ignored in sw low power");
    cyc(1, C_WAKE, 7, 2, "R7 exit request");
    cyc(0, C_INIT, 7, 2, "R7 exit held");
    cyc(0, C_INIT, 3, 0, "R7 access");

    // R11 hardware-triggered low power
    auto_lp_req = 1;
    cyc(0, C_INIT, 6, 1, "R11 hw entry");
    cyc(0, C_INIT, 6, 1, "R11 hw entry held");
    cyc(0, C_INIT, 5, 1, "R11 hw low power");
    cyc(1, C_WAKE, 5, 1, "R11 wake ignored");
    auto_lp_req = 0;
    cyc(0, C_INIT, 7, 1, "R11 hw exit");
    cyc(0, C_INIT, 7, 1, "R11 hw exit held");
    cyc(0, C_INIT, 3, 0, "R11 access");

    // R9 in access
    cyc(1, C_INIT, 3, 0, "R9 init in access");
    cyc(1, 3'd7, 3, 0, "R9 code 7");

    cmd_valid = 0;
    repeat (3) @(negedge clk);
    report();
  end

endmodule